// File: doc/BRIEF.md
# Video Mode Table with Priority Match

This block keeps a small table of output video modes. Each entry holds a width, a height and a valid flag. A host programs the table through a simple word-addressed register port. A separate request port presents a wanted resolution with a one-cycle strobe. On each strobe the block searches the valid entries for one whose width and height both equal the request. The lowest-numbered hit becomes the selected mode. Its index goes into a match register, and its dimensions are latched onto the active outputs that drive the timing generator downstream.

An entry's dimension registers accept writes only while its valid flag is clear. This gives a safe reconfiguration sequence: clear the flag, rewrite the dimensions, set the flag again. The latched active dimensions do not change during this sequence. They change only when a later request produces a new match.

Two pending interrupt bits are kept. One marks that a new mode was selected. The other marks an external alignment event. Each has an enable bit in the control register, and the host clears a pending bit by writing 1 to it. The single interrupt output is asserted when any pending bit is set and enabled.

Top module: `vmode_bank`

## Requirements
- R1: A write to an entry's width (address 9+4k, bits [11:0]) or height (address 10+4k, bits [11:0]) is stored only while that entry's valid bit is 0. While the bit is 1 the write is ignored and reading the register returns the earlier value.
- R2: Bit 0 of address 8+4k is entry k's valid flag. It is read/write. An entry whose flag is 0 is never selected, even when its dimensions equal the request. After the flag is set, the entry can be selected.
- R3: When a request strobe is given and several valid entries match, the match register takes the lowest matching index.
- R4: Clearing an entry's valid flag leaves its stored width and height unchanged.
- R5: The active width/height outputs and the match register change only on a request strobe. They keep their values while the selected entry is invalidated and rewritten. A strobe that finds a match latches that entry's dimensions.
- R6: The status pending bit (interrupt register bit 1) is set when a strobe finds a match whose code differs from the current match register. Re-matching the entry already selected does not set it.
- R7: A strobe with no valid match sets the match register (address 2, and the match_o port) to 0. It leaves the active dimensions unchanged and does not set the status pending bit. A non-zero match code is the entry index plus 1.
- R8: Control register (address 0) bits [2:1] enable the status and alignment interrupts. Interrupt register (address 1) bits [2:1] hold their pending state, and align_evt_i sets bit 2. Pending bits are set regardless of the enables. irq_o is the OR of the pending bits that are enabled.
- R9: Writing 1 to a pending bit clears it. If an event for that bit arrives in the same cycle as the clear, the bit stays set.
- R10: After reset the control, interrupt and match registers are 0, every valid flag is 0, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data (combinational from the address) |
| req_valid_i | input | 1 | Resolution request strobe |
| req_width_i | input | DIM_W | Requested width |
| req_height_i | input | DIM_W | Requested height |
| align_evt_i | input | 1 | Alignment event pulse, sets pending bit 2 |
| match_o | output | CODE_W | Selected mode code (index+1, 0 for none) |
| act_width_o | output | DIM_W | Latched active width |
| act_height_o | output | DIM_W | Latched active height |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters: four entries with 12-bit dimensions. With four entries it can program duplicate resolutions in entries 0/1 and 2/3. This reaches the cases where the lowest valid hit wins and where invalidating the winner hands the selection to the next entry. It also walks the selected entry through the invalidate, rewrite and revalidate sequence while it watches the latched outputs. Finally, it places an alignment event in the same cycle as a clear-by-write of that bit.

// File: rtl/vmode_pkg.sv
`timescale 1ns/1ps
package vmode_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned ADR_CTRL    = 0;
  localparam int unsigned ADR_IRQ     = 1;
  localparam int unsigned ADR_MATCH   = 2;
  localparam int unsigned ADR_MODE0   = 8;
  localparam int unsigned MODE_STRIDE = 4;
  localparam int unsigned IRQ_STATUS  = 1;
  localparam int unsigned IRQ_ALIGN   = 2;

  typedef enum logic [1:0] {
    FLD_VALID  = 2'd0,
    FLD_WIDTH  = 2'd1,
    FLD_HEIGHT = 2'd2
  } mode_fld_e;
endpackage

// File: rtl/vmode_entry.sv
`timescale 1ns/1ps
module vmode_entry #(
  parameter int unsigned DIM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             wr_width_i,
  input  logic             wr_height_i,
  input  logic             wbit_i,
  input  logic [DIM_W-1:0] wdim_i,
  output logic             valid_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o
);
  logic             valid_q;
  logic [DIM_W-1:0] width_q, height_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      width_q  <= '0;
      height_q <= '0;
    end else begin
      if (wr_valid_i)              valid_q  <= wbit_i;
      // dimensions locked while the entry is live
      if (wr_width_i  && !valid_q) width_q  <= wdim_i;
      if (wr_height_i && !valid_q) height_q <= wdim_i;
    end
  end

  assign valid_o  = valid_q;
  assign width_o  = width_q;
  assign height_o = height_q;

  // R1
  a_r1_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && (wr_width_i || wr_height_i) |=> $stable(width_q) && $stable(height_q));
  // R4
  a_r4_invalidate_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_q) |-> $stable(width_q) && $stable(height_q));
endmodule

// File: rtl/vmode_match.sv
`timescale 1ns/1ps
module vmode_match #(
  parameter int unsigned N_MODES = 4,
  parameter int unsigned DIM_W   = 12,
  localparam int unsigned IDX_W  = (N_MODES > 1) ? $clog2(N_MODES) : 1
) (
  input  logic [N_MODES-1:0]            valid_i,
  input  logic [N_MODES-1:0][DIM_W-1:0] width_i,
  input  logic [N_MODES-1:0][DIM_W-1:0] height_i,
  input  logic [DIM_W-1:0]              req_width_i,
  input  logic [DIM_W-1:0]              req_height_i,
  output logic                          found_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [N_MODES-1:0] hit;

  for (genvar k = 0; k < N_MODES; k++) begin : g_hit
    assign hit[k] = valid_i[k] && (width_i[k] == req_width_i) && (height_i[k] == req_height_i);
  end

  // scan downward so the lowest index is assigned last
  always_comb begin
    idx_o = '0;
    for (int k = N_MODES - 1; k >= 0; k--) begin
      if (hit[k]) idx_o = IDX_W'(k);
    end
  end

  assign found_o = |hit;

  // R3
  always_comb begin
    if (found_o) a_r3_lowest_hit: assert (hit[idx_o]);
  end
endmodule

// File: rtl/vmode_irq.sv
`timescale 1ns/1ps
module vmode_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:1] evt_i,
  input  logic [2:1] clr_i,
  input  logic [2:1] en_i,
  output logic [2:1] pend_o,
  output logic       irq_o
);
  logic [2:1] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | evt_i;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);

  for (genvar b = 1; b <= 2; b++) begin : g_chk
    // R9
    a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[b] |=> pend_q[b]);
    a_r9_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[b] && !evt_i[b] |=> !pend_q[b]);
  end
endmodule

// File: rtl/vmode_bank.sv
`timescale 1ns/1ps
module vmode_bank
  import vmode_pkg::*;
#(
  parameter int unsigned N_MODES = 4,
  parameter int unsigned DIM_W   = 12,
  parameter int unsigned ADDR_W  = 6,
  localparam int unsigned IDX_W  = (N_MODES > 1) ? $clog2(N_MODES) : 1,
  localparam int unsigned CODE_W = $clog2(N_MODES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [DIM_W-1:0]  req_width_i,
  input  logic [DIM_W-1:0]  req_height_i,
  input  logic              align_evt_i,
  output logic [CODE_W-1:0] match_o,
  output logic [DIM_W-1:0]  act_width_o,
  output logic [DIM_W-1:0]  act_height_o,
  output logic              irq_o
);
  logic [N_MODES-1:0]            mode_valid;
  logic [N_MODES-1:0][DIM_W-1:0] mode_w, mode_h;
  logic                          found;
  logic [IDX_W-1:0]              hit_idx;
  logic [CODE_W-1:0]             hit_code;
  logic [CODE_W-1:0]             match_q;
  logic [DIM_W-1:0]              act_w_q, act_h_q;
  logic [2:1]                    ctrl_q, pend, irq_evt, irq_clr;
  logic                          wr_ctrl, wr_irq;
  logic                          unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-1:DIM_W];

  function automatic logic [ADDR_W-1:0] mode_addr(int unsigned k, mode_fld_e f);
    return ADDR_W'(ADR_MODE0 + MODE_STRIDE * k + int'(f));
  endfunction

  for (genvar k = 0; k < N_MODES; k++) begin : g_mode
    vmode_entry #(.DIM_W(DIM_W)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_valid_i  (reg_we_i && reg_addr_i == mode_addr(k, FLD_VALID)),
      .wr_width_i  (reg_we_i && reg_addr_i == mode_addr(k, FLD_WIDTH)),
      .wr_height_i (reg_we_i && reg_addr_i == mode_addr(k, FLD_HEIGHT)),
      .wbit_i      (reg_wdata_i[0]),
      .wdim_i      (reg_wdata_i[DIM_W-1:0]),
      .valid_o     (mode_valid[k]),
      .width_o     (mode_w[k]),
      .height_o    (mode_h[k])
    );
  end

  vmode_match #(.N_MODES(N_MODES), .DIM_W(DIM_W)) u_match (
    .valid_i      (mode_valid),
    .width_i      (mode_w),
    .height_i     (mode_h),
    .req_width_i  (req_width_i),
    .req_height_i (req_height_i),
    .found_o      (found),
    .idx_o        (hit_idx)
  );

  assign hit_code = CODE_W'(hit_idx) + CODE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      act_w_q <= '0;
      act_h_q <= '0;
    end else if (req_valid_i) begin
      if (found) begin
        match_q <= hit_code;
        act_w_q <= mode_w[hit_idx];
        act_h_q <= mode_h[hit_idx];
      end else begin
        match_q <= '0;
      end
    end
  end

  assign wr_ctrl = reg_we_i && reg_addr_i == ADDR_W'(ADR_CTRL);
  assign wr_irq  = reg_we_i && reg_addr_i == ADDR_W'(ADR_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata_i[2:1];
  end

  assign irq_evt[IRQ_STATUS] = req_valid_i && found && (hit_code != match_q);
  assign irq_evt[IRQ_ALIGN]  = align_evt_i;
  assign irq_clr             = wr_irq ? reg_wdata_i[2:1] : 2'b00;

  vmode_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (irq_evt),
    .clr_i  (irq_clr),
    .en_i   (ctrl_q),
    .pend_o (pend),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADR_CTRL))  reg_rdata_o[2:1] = ctrl_q;
    if (reg_addr_i == ADDR_W'(ADR_IRQ))   reg_rdata_o[2:1] = pend;
    if (reg_addr_i == ADDR_W'(ADR_MATCH)) reg_rdata_o[CODE_W-1:0] = match_q;
    for (int unsigned k = 0; k < N_MODES; k++) begin
      if (reg_addr_i == mode_addr(k, FLD_VALID))  reg_rdata_o[0] = mode_valid[k];
      if (reg_addr_i == mode_addr(k, FLD_WIDTH))  reg_rdata_o[DIM_W-1:0] = mode_w[k];
      if (reg_addr_i == mode_addr(k, FLD_HEIGHT)) reg_rdata_o[DIM_W-1:0] = mode_h[k];
    end
  end

  assign match_o      = match_q;
  assign act_width_o  = act_w_q;
  assign act_height_o = act_h_q;

  // R5
  a_r5_hold_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(match_q) && $stable(act_w_q) && $stable(act_h_q));
  // R6
  a_r6_status_on_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && found && (hit_code != match_q) |=> pend[IRQ_STATUS]);
  // R7
  a_r7_nomatch_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !found |=> (match_q == '0) && $stable(act_w_q));
endmodule

// File: tb/vmode_bank_bench.sv
`timescale 1ns/1ps
module vmode_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req = 1'b0;
  logic [11:0] req_w = '0, req_h = '0;
  logic        align = 1'b0;
  logic [2:0]  match;
  logic [11:0] act_w, act_h;
  logic        irq;
  int          n_vec = 0, n_err = 0;

  always #10 clk = ~clk;

  vmode_bank u_vmode_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .req_valid_i(req), .req_width_i(req_w), .req_height_i(req_h),
    .align_evt_i(align), .match_o(match),
    .act_width_o(act_w), .act_height_o(act_h), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic request(input logic [11:0] w, input logic [11:0] h);
    @(negedge clk); req_w = w; req_h = h; req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic pulse_align();
    @(negedge clk); align = 1'b1;
    @(negedge clk); align = 1'b0;
  endtask

  task automatic t_reset();
    rd("R10 ctrl", 6'd0, 0);
    rd("R10 irq reg", 6'd1, 0);
    rd("R10 match", 6'd2, 0);
    rd("R10 valid0", 6'd8, 0);
    chk("R10 irq_o", irq, 0);
  endtask

  task automatic t_write_protect();
    wr(6'd9, 640); wr(6'd10, 480);
    rd("R1 width stored while invalid", 6'd9, 640);
    request(640, 480);
    chk("R2 invalid entry not selected", match, 0);
    wr(6'd8, 1);
    rd("R2 valid flag read", 6'd8, 1);
    wr(6'd9, 100); wr(6'd10, 7);
    rd("R1 width write ignored", 6'd9, 640);
    rd("R1 height write ignored", 6'd10, 480);
    wr(6'd13, 640); wr(6'd14, 480);
  endtask

  task automatic t_select();
    wr(6'd0, 2);
    rd("R8 ctrl readback", 6'd0, 2);
    request(640, 480);
    chk("R2 entry0 selected", match, 1);
    rd("R7 match register code", 6'd2, 1);
    chk("R5 act width", act_w, 640);
    chk("R5 act height", act_h, 480);
    rd("R6 status pending", 6'd1, 2);
    chk("R8 irq_o enabled", irq, 1);
    wr(6'd1, 2);
    rd("R9 w1c clears", 6'd1, 0);
    chk("R9 irq_o drops", irq, 0);
  endtask

  task automatic t_priority();
    wr(6'd12, 1);
    request(640, 480);
    chk("R3 lowest of two wins", match, 1);
    rd("R6 no status on same mode", 6'd1, 0);
    wr(6'd8, 0);
    rd("R4 width kept", 6'd9, 640);
    rd("R4 height kept", 6'd10, 480);
    request(640, 480);
    chk("R3 next entry after invalidate", match, 2);
    rd("R6 status on new mode", 6'd1, 2);
    wr(6'd1, 2);
    wr(6'd17, 1920); wr(6'd18, 1080); wr(6'd21, 1920); wr(6'd22, 1080);
    wr(6'd16, 1); wr(6'd20, 1);
    request(1920, 1080);
    chk("R3 entry2 over entry3", match, 3);
    wr(6'd1, 2);
    request(640, 480);
    chk("R3 back to entry1", match, 2);
    wr(6'd1, 2);
  endtask

  task automatic t_hold();
    wr(6'd12, 0); wr(6'd13, 800); wr(6'd14, 600);
    chk("R5 act width held during rewrite", act_w, 640);
    chk("R5 act height held during rewrite", act_h, 480);
    chk("R5 match held during rewrite", match, 2);
    wr(6'd12, 1);
    request(800, 600);
    chk("R5 rematch same entry", match, 2);
    chk("R5 new width latched", act_w, 800);
    chk("R5 new height latched", act_h, 600);
    rd("R6 no status on same code", 6'd1, 0);
  endtask

  task automatic t_nomatch();
    request(800, 480);
    chk("R7 match zero", match, 0);
    chk("R7 act width kept", act_w, 800);
    rd("R7 no status", 6'd1, 0);
    request(800, 600);
    chk("R6 match again", match, 2);
    rd("R6 status from zero", 6'd1, 2);
    wr(6'd1, 2);
  endtask

  task automatic t_enables();
    wr(6'd0, 0);
    pulse_align();
    rd("R8 align pending", 6'd1, 4);
    chk("R8 irq_o masked", irq, 0);
    wr(6'd0, 4);
    chk("R8 irq_o align enabled", irq, 1);
    wr(6'd0, 2);
    chk("R8 irq_o other enable only", irq, 0);
    wr(6'd1, 4);
    rd("R9 align cleared", 6'd1, 0);
  endtask

  task automatic t_race();
    @(negedge clk); align = 1'b1; addr = 6'd1; wdata = 4; we = 1'b1;
    @(negedge clk); align = 1'b0; we = 1'b0;
    rd("R9 event beats clear", 6'd1, 4);
    wr(6'd1, 4);
    rd("R9 cleared after", 6'd1, 0);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_write_protect();
    t_select();
    t_priority();
    t_hold();
    t_nomatch();
    t_enables();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule